// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-based processor. Each cycle it takes an accumulator value, a second operand, an incoming carry bit and a 4-bit operation code. It computes one of fourteen operations: four add/subtract forms, a compare, increment, decrement, three bitwise operations and four rotates. When the write enable is high, it stores the new result and a packed status byte in output registers.

The status byte holds sign, zero, nibble-carry, even-parity and carry bits at fixed positions. Flags that an operation leaves alone keep their stored values. The carry used by add-with-carry, subtract-with-borrow and the rotate-through-carry forms always comes from the `cy_in` port. The carry that increment and decrement preserve is the stored carry flag. Compare updates every flag but leaves the stored result untouched, so the surrounding datapath can skip the accumulator writeback.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_q` becomes 0 and `flags_q` becomes 8'h02.
- R2: The `flags_q` layout is: sign at bit 7, zero at bit 6, nibble carry (AC) at bit 4, parity at bit 2 and carry (CY) at bit 0. Bit 1 is always 1, and bits 5 and 3 are always 0.
- R3: For every operation that updates the flags except rotates, sign equals result bit 7, zero is set when the 8-bit result is 0, and parity is set when the result has an even number of 1 bits. For compare, the result used is the difference.
- R4: Opcode 0 (add) stores A+B, and opcode 1 (add with carry) stores A+B+`cy_in`. CY is the carry out of bit 7, and AC is the carry out of bit 3 into bit 4.
- R5: Opcode 2 (subtract) stores A−B, and opcode 3 (subtract with borrow) stores A−B−`cy_in`. CY is set on a borrow out of bit 7. AC is set when the low nibble of A is at least the low nibble of B plus the borrow in, which is the bit-3 carry of the complement addition.
- R6: Opcode 4 (compare) sets all five flags exactly as opcode 2 would, and `res_q` keeps its previous value.
- R7: Opcode 5 (increment) stores A+1, with AC set when A[3:0] is 4'hF. Opcode 6 (decrement) stores A−1, with AC set when A[3:0] is not 0. Both keep CY unchanged and update sign, zero and parity.
- R8: Opcodes 7, 8 and 9 store A AND B, A OR B and A XOR B, and all three clear CY. AC is 1 after AND and 0 after OR or XOR.
- R9: Opcodes 10 to 13 are rotates and change only CY among the flags:
  - Opcode 10 rotates left, with bit 7 going into both bit 0 and CY.
  - Opcode 11 rotates right, with bit 0 going into both bit 7 and CY.
  - Opcode 12 rotates left through carry: `cy_in` enters bit 0 and bit 7 goes to CY.
  - Opcode 13 rotates right through carry: `cy_in` enters bit 7 and bit 0 goes to CY.
- R10: When `wr_en` is low at a clock edge, `res_q` and `flags_q` keep their values.
- R11: Opcodes 14 and 15 change neither `res_q` nor `flags_q`, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register the result and flags this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B |
| cy_in | input | 1 | Incoming carry for carry, borrow and rotate-through-carry forms |
| res_q | output | 8 | Registered result |
| flags_q | output | 8 | Registered status byte |

## Verification
On every cycle, the assertions check the following:
- the hold behaviour with the write enable low or a reserved opcode;
- that compare leaves the result untouched;
- the sign, zero and parity relation between the stored result and the stored flags;
- the carry rules that hold regardless of operand values (kept on increment and decrement, cleared on bitwise operations, AC after AND);
- that rotates leave the upper flags alone.

The actual arithmetic values can only be shown by the bench's scenarios, because the assertions do not see the operands. These values are the sums, the differences with borrow, the nibble-carry corner cases at 4'hF and 4'h0, the rotate bit movements, and the reset values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_RLC  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RAL  = 4'd12,
    OP_RAR  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  localparam int FLAG_W   = 8;
  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_HALF  = 4;
  localparam int FB_PAR   = 2;
  localparam int FB_ONE   = 1;
  localparam int FB_CARRY = 0;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              half
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] b_eff;
  logic              c_first;
  logic [LO_W:0]     lo_sum;
  logic [HI_W:0]     hi_sum;

  // Subtraction is the addition of the complement; the carry-in is inverted
  // so that a borrow-in of 1 removes one extra unit.
  assign b_eff   = sub ? ~b : b;
  assign c_first = sub ? ~cin : cin;

  assign lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, c_first};
  assign hi_sum = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b_eff[DATA_W-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign half = lo_sum[LO_W];
  // Carry out of the top bit means "no borrow" when subtracting.
  assign cout = sub ? ~hi_sum[HI_W] : hi_sum[HI_W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_sel_e        sel,
  output logic [DATA_W-1:0] r,
  output logic              half
);
  always_comb begin
    unique case (sel)
      LG_AND:  r = a & b;
      LG_OR:   r = a | b;
      default: r = a ^ b;
    endcase
    half = (sel == LG_AND);
  end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              right,
  input  logic              thru,
  output logic [DATA_W-1:0] r,
  output logic              cy_out
);
  logic fill_l;
  logic fill_r;

  // Bit entering the vacated position: the bit shifted out, or the carry-in.
  assign fill_l = thru ? cin : a[DATA_W-1];
  assign fill_r = thru ? cin : a[0];

  always_comb begin
    if (right) begin
      r      = {fill_r, a[DATA_W-1:1]};
      cy_out = a[0];
    end else begin
      r      = {a[DATA_W-2:0], fill_l};
      cy_out = a[DATA_W-1];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res_q,
  output logic [7:0]        flags_q
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // Adder controls
  logic [DATA_W-1:0] as_b;
  logic              as_cin;
  logic              as_sub;
  logic [DATA_W-1:0] as_sum;
  logic              as_cout;
  logic              as_half;

  // Logic and rotate controls
  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] lg_res;
  logic              lg_half;
  logic              rt_right;
  logic              rt_thru;
  logic [DATA_W-1:0] rt_res;
  logic              rt_cy;

  // Stored state
  flag_set_t         flg_q;

  // Next-state selection
  logic [DATA_W-1:0] nxt_res;
  flag_set_t         nxt_flg;
  logic              upd_res;
  logic              upd_flg;

  always_comb begin
    as_b   = opnd_in;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op_e)
      OP_ADC:         as_cin = cy_in;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin
        as_sub = 1'b1;
        as_cin = cy_in;
      end
      OP_INC: begin
        as_b   = '0;
        as_cin = 1'b1;
      end
      OP_DEC: begin
        as_b   = DATA_W'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op_e)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
    rt_right = (op_e == OP_RRC) || (op_e == OP_RAR);
    rt_thru  = (op_e == OP_RAL) || (op_e == OP_RAR);
  end

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a    (acc_in),
    .b    (as_b),
    .cin  (as_cin),
    .sub  (as_sub),
    .sum  (as_sum),
    .cout (as_cout),
    .half (as_half)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a    (acc_in),
    .b    (opnd_in),
    .sel  (lg_sel),
    .r    (lg_res),
    .half (lg_half)
  );

  acc_alu_rotate #(.DATA_W(DATA_W)) u_rotate (
    .a      (acc_in),
    .cin    (cy_in),
    .right  (rt_right),
    .thru   (rt_thru),
    .r      (rt_res),
    .cy_out (rt_cy)
  );

  // Pick the result and the flag updates for each operation class.
  always_comb begin
    logic [DATA_W-1:0] szp_src;
    nxt_res = res_q;
    nxt_flg = flg_q;
    upd_res = 1'b0;
    upd_flg = 1'b0;
    szp_src = as_sum;
    unique case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        nxt_res    = as_sum;
        nxt_flg.ac = as_half;
        nxt_flg.cy = as_cout;
        upd_res    = (op_e != OP_CMP);
        upd_flg    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        nxt_res    = as_sum;
        nxt_flg.ac = as_half;
        upd_res    = 1'b1;
        upd_flg    = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt_res    = lg_res;
        nxt_flg.ac = lg_half;
        nxt_flg.cy = 1'b0;
        szp_src    = lg_res;
        upd_res    = 1'b1;
        upd_flg    = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        nxt_res    = rt_res;
        nxt_flg.cy = rt_cy;
        upd_res    = 1'b1;
        upd_flg    = 1'b1;
      end
      default: ;
    endcase
    if (upd_flg && !rt_class(op_e)) begin
      nxt_flg.s = szp_src[DATA_W-1];
      nxt_flg.z = (szp_src == '0);
      nxt_flg.p = ~^szp_src;
    end
  end

  function automatic logic rt_class(input alu_op_e o);
    return (o == OP_RLC) || (o == OP_RRC) || (o == OP_RAL) || (o == OP_RAR);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (wr_en) begin
      if (upd_res) res_q <= nxt_res;
      if (upd_flg) flg_q <= nxt_flg;
    end
  end

  always_comb begin
    flags_q           = '0;
    flags_q[FB_SIGN]  = flg_q.s;
    flags_q[FB_ZERO]  = flg_q.z;
    flags_q[FB_HALF]  = flg_q.ac;
    flags_q[FB_PAR]   = flg_q.p;
    flags_q[FB_ONE]   = 1'b1;
    flags_q[FB_CARRY] = flg_q.cy;
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] res_q,
  input logic [7:0]        flags_q
);
  logic is_szp_op;
  logic is_rot;
  assign is_szp_op = (op <= 4'd9) && (op != 4'd4);
  assign is_rot    = (op >= 4'd10) && (op <= 4'd13);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(res_q) && $stable(flags_q)));

  assert_reserved_noop_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op >= 4'd14) |=> ($stable(res_q) && $stable(flags_q)));

  assert_cmp_no_writeback_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 4'd4) |=> $stable(res_q));

  assert_szp_match_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_szp_op) |=> (flags_q[FB_SIGN] == res_q[DATA_W-1]
                              && flags_q[FB_ZERO] == (res_q == '0)
                              && flags_q[FB_PAR] == ~^res_q));

  assert_incdec_keep_cy_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op == 4'd5 || op == 4'd6)) |=> (flags_q[FB_CARRY] == $past(flags_q[FB_CARRY])));

  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op >= 4'd7 && op <= 4'd9) |=>
      (!flags_q[FB_CARRY] && flags_q[FB_HALF] == ($past(op) == 4'd7)));

  assert_rotate_only_cy_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_rot) |=> (flags_q[7:1] == $past(flags_q[7:1])));

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |=> (flags_q[FB_ONE] && !flags_q[5] && !flags_q[3]));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_acc_alu_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .op      (op),
  .res_q   (res_q),
  .flags_q (flags_q)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opnd_in = 8'h00;
  logic       cy_in = 1'b0;
  logic [7:0] res_q;
  logic [7:0] flags_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_res;
  logic [7:0] exp_fl;

  always #2 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in),
    .res_q(res_q), .flags_q(flags_q)
  );

  // {op, A, B, carry-in}
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    {4'd0,  8'h3A, 8'hC6, 1'b0},
    {4'd5,  8'h0F, 8'h00, 1'b0},
    {4'd0,  8'h0F, 8'h01, 1'b0},
    {4'd1,  8'h7F, 8'h00, 1'b1},
    {4'd1,  8'hFF, 8'hFF, 1'b1},
    {4'd6,  8'h00, 8'h00, 1'b0},
    {4'd2,  8'h10, 8'h01, 1'b0},
    {4'd2,  8'h05, 8'h07, 1'b0},
    {4'd3,  8'h00, 8'h00, 1'b1},
    {4'd3,  8'h50, 8'h20, 1'b0},
    {4'd4,  8'h42, 8'h42, 1'b0},
    {4'd4,  8'h10, 8'h20, 1'b0},
    {4'd5,  8'hFF, 8'h00, 1'b0},
    {4'd6,  8'h10, 8'h00, 1'b1},
    {4'd7,  8'hF0, 8'h3C, 1'b0},
    {4'd8,  8'h00, 8'h00, 1'b1},
    {4'd9,  8'hAA, 8'h55, 1'b0},
    {4'd10, 8'h81, 8'h00, 1'b0},
    {4'd11, 8'h01, 8'h00, 1'b0},
    {4'd12, 8'h80, 8'h00, 1'b0},
    {4'd13, 8'h01, 8'h00, 1'b1},
    {4'd12, 8'h7F, 8'h00, 1'b1},
    {4'd11, 8'h02, 8'h00, 1'b1},
    {4'd13, 8'hFE, 8'h00, 1'b0}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:        return "R4";
      4'd2, 4'd3:        return "R5";
      4'd4:              return "R6";
      4'd5, 4'd6:        return "R7";
      4'd7, 4'd8, 4'd9:  return "R8";
      4'd10, 4'd11, 4'd12, 4'd13: return "R9";
      default:           return "R11";
    endcase
  endfunction

  function automatic logic [7:0] pack(input logic s, input logic z, input logic ac,
                                      input logic p, input logic cy);
    return {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  // Reference model written from the requirements (R2..R9, R11).
  task automatic model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c);
    int t;
    logic [7:0] r;
    logic s, z, ac, p, cy, szp;
    s = exp_fl[7]; z = exp_fl[6]; ac = exp_fl[4]; p = exp_fl[2]; cy = exp_fl[0];
    r = exp_res;
    szp = 1'b1;
    case (o)
      4'd0, 4'd1: begin
        t  = int'(a) + int'(b) + ((o == 4'd1) ? int'(c) : 0);
        r  = t[7:0];
        cy = (t > 255);
        ac = ((int'(a[3:0]) + int'(b[3:0]) + ((o == 4'd1) ? int'(c) : 0)) > 15);
      end
      4'd2, 4'd3, 4'd4: begin
        t  = int'(a) - int'(b) - ((o == 4'd3) ? int'(c) : 0);
        r  = t[7:0];
        cy = (t < 0);
        ac = (int'(a[3:0]) >= int'(b[3:0]) + ((o == 4'd3) ? int'(c) : 0));
      end
      4'd5: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); end
      4'd6: begin r = a - 8'd1; ac = (a[3:0] != 4'h0); end
      4'd7: begin r = a & b; ac = 1'b1; cy = 1'b0; end
      4'd8: begin r = a | b; ac = 1'b0; cy = 1'b0; end
      4'd9: begin r = a ^ b; ac = 1'b0; cy = 1'b0; end
      4'd10: begin r = {a[6:0], a[7]}; cy = a[7]; szp = 1'b0; end
      4'd11: begin r = {a[0], a[7:1]}; cy = a[0]; szp = 1'b0; end
      4'd12: begin r = {a[6:0], c};    cy = a[7]; szp = 1'b0; end
      4'd13: begin r = {c, a[7:1]};    cy = a[0]; szp = 1'b0; end
      default: szp = 1'b0;
    endcase
    if (szp) begin
      s = r[7];
      z = (r == 8'h00);
      p = ~^r;
    end
    if (o <= 4'd13) begin
      if (o != 4'd4) exp_res = r;
      exp_fl = pack(s, z, ac, p, cy);
    end
  endtask

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
  task automatic step(input logic we, input logic [3:0] o, input logic [7:0] a,
                      input logic [7:0] b, input logic c);
    wr_en = we; op = o; acc_in = a; opnd_in = b; cy_in = c;
    if (we) model(o, a, b, c);
    @(negedge clk);
    check(we ? req_of(o) : "R10", "result", res_q, exp_res);
    check(we ? req_of(o) : "R10", "flags R2", flags_q, exp_fl);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset values
    exp_res = 8'h00;
    exp_fl  = 8'h02;
    check("R1", "reset result", res_q, 8'h00);
    check("R1", "reset flags", flags_q, 8'h02);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][20:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end

    // R10: write enable low with an operation that would change everything
    step(1'b1, 4'd0, 8'h3A, 8'hC6, 1'b0);
    step(1'b0, 4'd9, 8'h5A, 8'hFF, 1'b1);
    step(1'b0, 4'd10, 8'h81, 8'h00, 1'b0);

    // R11: reserved opcodes with write enable high
    step(1'b1, 4'd8, 8'h81, 8'h00, 1'b0);
    step(1'b1, 4'd14, 8'h00, 8'h00, 1'b1);
    step(1'b1, 4'd15, 8'hFF, 8'h01, 1'b1);

    // R6: compare right after a result that differs from the difference
    step(1'b1, 4'd7, 8'h3C, 8'h3C, 1'b0);
    step(1'b1, 4'd4, 8'h01, 8'h02, 1'b0);

    // R7: increment keeps a set carry
    step(1'b1, 4'd2, 8'h00, 8'h01, 1'b0);
    step(1'b1, 4'd5, 8'h7F, 8'h00, 1'b0);
    step(1'b1, 4'd6, 8'h01, 8'h00, 1'b0);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset again result", res_q, 8'h00);
    check("R1", "reset again flags", flags_q, 8'h02);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule